// File: doc/BRIEF.md
# Framed Serial ADC Word Reader

This block fetches one 12-bit conversion result from an analog-to-digital converter over a three-wire serial link. The block is the link master. It drives an active-low frame strobe and a serial clock. It reads the converter's data line one bit per serial-clock fall and presents the finished word together with a single-cycle valid strobe.

All link timing is counted in system-clock cycles. The minimum times are given as parameters in picoseconds. Each phase length is the minimum time divided by the system-clock period and rounded up, and a phase is never shorter than one cycle. The serial clock rests high while no frame is running. A read request taken in the idle state starts exactly one frame.

The result leaves the block as a plain strobe with no ready signal. The consumer cannot stall it and must take the word in the cycle the strobe is high. The word then holds until the next strobe. Requests that arrive while a frame or its closing gap is running are dropped; they are not queued.

Top module: `sadc_frame_reader`

## Requirements
- R1: The result is the 12 data-line bits taken at the 12 serial-clock falls of a frame, first bit into bit 11 (MSB first). `word_o` changes only in the cycle the valid strobe is high.
- R2: A request seen in idle drives `frame_n_o` low on the next clock. The first serial-clock fall comes SETUP cycles later, with SETUP = ceil(max(35 ns setup, 30 ns first-bit delay) / period), which is 4 at 100 MHz.
- R3: Each serial-clock low phase lasts LOW = ceil(25 ns / period) cycles, which is 3. Each high phase inside the frame lasts HIGH = ceil(max(25 ns, 30 ns data delay) / period) cycles, which is 3. Serial-clock falls happen only while `frame_n_o` is low.
- R4: Exactly 12 serial-clock falls occur per frame. The serial clock is high whenever `frame_n_o` is high.
- R5: After the 12th low phase the serial clock rises and `frame_n_o` stays low for HOLD = max(1, ceil(30 ns / period) − LOW) more cycles, which is 1, before it rises.
- R6: `word_valid_o` is high for exactly one cycle: the first cycle in which `frame_n_o` is high again.
- R7: Requests that arrive while a frame is in progress, including its closing gap, are ignored. They cause no extra frame.
- R8: During and right after reset, `frame_n_o` = 1, `sclk_o` = 1, `word_valid_o` = 0 and `word_o` = 0. A reset in mid-frame aborts the frame.
- R9: After `frame_n_o` rises the block waits GAP = ceil(30 ns / period) cycles, which is 3, before a new request can be taken. A request held high therefore restarts the frame one cycle after the gap ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read request, taken only when idle |
| sdata_i | input | 1 | Serial data line from the converter |
| frame_n_o | output | 1 | Frame strobe, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| word_o | output | WORD_W | Last assembled result |
| word_valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The data words include all ones, all zeros, alternating patterns and single set bits at either end. These show whether the bit order is wrong, whether a bit is dropped, or whether the sample point has shifted by one clock edge. Between frames and after the last bit, the converter model toggles junk on the data line, so a sample taken off the falling edge corrupts the word. Requests are sent as single pulses, as pulses during the frame and during the closing gap, and as a level held high across several frames. These separate ignoring a request from accepting it too early. A reset in mid-frame confirms the abort returns the link to rest.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_GAP
  } sadc_state_e;

  function automatic int ceil_div(int num, int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sadc_phase_timer.sv
module sadc_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  // load_val_i is (phase length - 1); done marks the last cycle of the phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sadc_shift_in.sv
module sadc_shift_in #(
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] sr_q;

  // first bit ends up in the MSB after WORD_W shifts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (shift_i) begin
      sr_q <= {sr_q[WORD_W-2:0], bit_i};
    end
  end

  assign word_o = sr_q;

endmodule

// File: rtl/sadc_frame_reader.sv
module sadc_frame_reader
  import sadc_pkg::*;
#(
  parameter int WORD_W          = 12,
  parameter int SYS_CLK_PS      = 10000,
  parameter int T_FS_SETUP_PS   = 35000,
  parameter int T_FIRST_BIT_PS  = 30000,
  parameter int T_SCLK_PHASE_PS = 25000,
  parameter int T_DATA_DELAY_PS = 30000,
  parameter int T_FS_HOLD_PS    = 30000,
  parameter int T_RELEASE_PS    = 30000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              sdata_i,
  output logic              frame_n_o,
  output logic              sclk_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);

  localparam int SETUP_CYC = max2(1, ceil_div(max2(T_FS_SETUP_PS, T_FIRST_BIT_PS), SYS_CLK_PS));
  localparam int LOW_CYC   = max2(1, ceil_div(T_SCLK_PHASE_PS, SYS_CLK_PS));
  localparam int HIGH_CYC  = max2(1, ceil_div(max2(T_SCLK_PHASE_PS, T_DATA_DELAY_PS), SYS_CLK_PS));
  // hold is measured from the last fall, which already lies LOW_CYC back
  localparam int HOLD_CYC  = max2(1, ceil_div(T_FS_HOLD_PS, SYS_CLK_PS) - LOW_CYC);
  localparam int GAP_CYC   = max2(1, ceil_div(T_RELEASE_PS, SYS_CLK_PS));
  localparam int MAX_CYC   = max2(max2(SETUP_CYC, LOW_CYC), max2(max2(HIGH_CYC, HOLD_CYC), GAP_CYC));
  localparam int CNT_W     = max2(1, $clog2(MAX_CYC));
  localparam int BIT_W     = $clog2(WORD_W + 1);

  sadc_state_e       state_q, state_d;
  logic              fs_q, fs_d;
  logic              sclk_q, sclk_d;
  logic              valid_q, valid_d;
  logic [WORD_W-1:0] result_q;
  logic [BIT_W-1:0]  bits_q;
  logic              tmr_load, tmr_done, shift_en, take_word, frame_start;
  logic [CNT_W-1:0]  tmr_val;
  logic [WORD_W-1:0] shift_word;

  sadc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sadc_shift_in #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_en),
    .bit_i   (sdata_i),
    .word_o  (shift_word)
  );

  always_comb begin
    state_d     = state_q;
    fs_d        = fs_q;
    sclk_d      = sclk_q;
    valid_d     = 1'b0;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    shift_en    = 1'b0;
    take_word   = 1'b0;
    frame_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rd_req_i) begin
          state_d     = ST_SETUP;
          fs_d        = 1'b0;
          frame_start = 1'b1;
          tmr_load    = 1'b1;
          tmr_val     = CNT_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP, ST_HIGH: begin
        if (tmr_done) begin
          // clock falls on this edge; the line is read at the same edge
          state_d  = ST_LOW;
          sclk_d   = 1'b0;
          shift_en = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(LOW_CYC - 1);
        end
      end
      ST_LOW: begin
        if (tmr_done) begin
          sclk_d   = 1'b1;
          tmr_load = 1'b1;
          if (bits_q == BIT_W'(WORD_W)) begin
            state_d = ST_HOLD;
            tmr_val = CNT_W'(HOLD_CYC - 1);
          end else begin
            state_d = ST_HIGH;
            tmr_val = CNT_W'(HIGH_CYC - 1);
          end
        end
      end
      ST_HOLD: begin
        if (tmr_done) begin
          state_d   = ST_GAP;
          fs_d      = 1'b1;
          valid_d   = 1'b1;
          take_word = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = CNT_W'(GAP_CYC - 1);
        end
      end
      ST_GAP: begin
        if (tmr_done) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      fs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      valid_q  <= 1'b0;
      result_q <= '0;
      bits_q   <= '0;
    end else begin
      state_q <= state_d;
      fs_q    <= fs_d;
      sclk_q  <= sclk_d;
      valid_q <= valid_d;
      if (take_word) begin
        result_q <= shift_word;
      end
      if (frame_start) begin
        bits_q <= '0;
      end else if (shift_en) begin
        bits_q <= bits_q + BIT_W'(1);
      end
    end
  end

  assign frame_n_o    = fs_q;
  assign sclk_o       = sclk_q;
  assign word_o       = result_q;
  assign word_valid_o = valid_q;

endmodule

// File: rtl/sadc_frame_reader_chk.sv
module sadc_frame_reader_chk #(
  parameter int WORD_W    = 12,
  parameter int SETUP_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_n_o,
  input logic              sclk_o,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o
);

  logic sclk_prev;
  int   fall_cnt;
  int   low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev <= 1'b1;
      fall_cnt  <= 0;
      low_cnt   <= 0;
    end else begin
      sclk_prev <= sclk_o;
      if (frame_n_o) begin
        fall_cnt <= 0;
        low_cnt  <= 0;
      end else begin
        if (sclk_prev && !sclk_o) fall_cnt <= fall_cnt + 1;
        if (low_cnt < 1000000) low_cnt <= low_cnt + 1;
      end
    end
  end

  assert_idle_clock_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_n_o |-> sclk_o);

  assert_fall_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> !frame_n_o);

  assert_fall_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_n_o) |-> (fall_cnt == WORD_W));

  assert_first_fall_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sclk_o) && (fall_cnt == 0)) |-> (low_cnt >= SETUP_CYC));

  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  assert_valid_at_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (frame_n_o && !$past(frame_n_o)));

  assert_word_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> $stable(word_o));

endmodule

bind sadc_frame_reader sadc_frame_reader_chk #(
  .WORD_W    (WORD_W),
  .SETUP_CYC (SETUP_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_n_o    (frame_n_o),
  .sclk_o       (sclk_o),
  .word_o       (word_o),
  .word_valid_o (word_valid_o)
);

// File: tb/sim_sadc_frame_reader.sv
module sim_sadc_frame_reader;

  localparam int P_NS = 10;
  localparam int W    = 12;
  // phase lengths taken from the requirements, rounded up to whole cycles
  localparam int S      = (35 + P_NS - 1) / P_NS;
  localparam int L      = (25 + P_NS - 1) / P_NS;
  localparam int H      = (30 + P_NS - 1) / P_NS;
  localparam int D_RAW  = (30 + P_NS - 1) / P_NS - L;
  localparam int D      = (D_RAW < 1) ? 1 : D_RAW;
  localparam int G      = (30 + P_NS - 1) / P_NS;
  localparam int FS_LEN = S + W * L + (W - 1) * H + D;
  localparam int FR_LEN = FS_LEN + G;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic sdata = 1'b0;
  logic fs, sclk, valid;
  logic [W-1:0] word;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sadc_frame_reader u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rd_req_i     (req),
    .sdata_i      (sdata),
    .frame_n_o    (fs),
    .sclk_o       (sclk),
    .word_o       (word),
    .word_valid_o (valid)
  );

  function automatic logic [W-1:0] pat(int i);
    case (i)
      0: return 12'hFFF;
      1: return 12'h000;
      2: return 12'hA5A;
      3: return 12'h5A5;
      4: return 12'h800;
      5: return 12'h001;
      default: return W'((i * 1187 + 91) ^ (i << 5));
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // reference model: frame position t counted in cycles after acceptance
  bit busy = 0;
  int t = 0;
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      busy = 0;
      t = 0;
    end else if (busy) begin
      if (t == FR_LEN) busy = 0;
      else t++;
    end else if (req) begin
      busy = 1;
      t = 1;
    end
  end

  logic [W-1:0] exp_q[$];
  logic [W-1:0] cur_word = '0;
  int frame_idx = 0;
  int bit_idx = -1;
  int falls = 0;
  logic prev_fs = 1'b1;
  logic prev_sclk = 1'b1;
  logic junk = 1'b0;

  always @(negedge clk) begin
    logic e_fs, e_sclk, e_valid;
    int u;
    if (rst_n) begin
      e_fs = 1'b1; e_sclk = 1'b1; e_valid = 1'b0;
      if (busy) begin
        e_fs = (t > FS_LEN);
        u = t - S - 1;
        if (t > S && u < W * (L + H) && (u % (L + H)) < L) e_sclk = 1'b0;
        e_valid = (t == FS_LEN + 1);
      end
      check("frame strobe R2 R5 R7 R9", 32'(fs), 32'(e_fs));
      check("serial clock R3 R4", 32'(sclk), 32'(e_sclk));
      check("valid strobe R6", 32'(valid), 32'(e_valid));
      if (valid && e_valid) begin
        if (exp_q.size() == 0) check("word R1 (no frame pending)", 32'(word), 32'hFFFF_FFFF);
        else check("word R1", 32'(word), 32'(exp_q.pop_front()));
      end
      if (prev_fs && !fs) falls = 0;
      if (prev_sclk && !sclk) falls++;
      if (!prev_fs && fs) check("falls per frame R4", 32'(falls), 32'(W));
    end
    // converter model
    junk = ~junk;
    if (prev_fs && !fs) begin
      cur_word = pat(frame_idx);
      frame_idx++;
      exp_q.push_back(cur_word);
      bit_idx = W - 1;
      sdata = cur_word[bit_idx];
    end else if (!fs && !prev_sclk && sclk) begin
      bit_idx--;
      sdata = (bit_idx >= 0) ? cur_word[bit_idx] : junk;
    end else if (fs) begin
      bit_idx = -1;
      sdata = junk;
    end
    prev_fs = fs;
    prev_sclk = sclk;
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_rest(string tag);
    check({tag, " frame strobe"}, 32'(fs), 32'd1);
    check({tag, " serial clock"}, 32'(sclk), 32'd1);
    check({tag, " valid"}, 32'(valid), 32'd0);
  endtask

  task automatic pulse_req();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    wait_cyc(4);
    check_rest("reset R8");
    check("reset R8 word", 32'(word), 32'd0);
    rst_n = 1'b1;
    wait_cyc(5);
    check_rest("idle after reset R8");

    // single pulses, plus stray requests during the frame and its gap (R7)
    for (int f = 0; f < 3; f++) begin
      pulse_req();
      wait_cyc(20);
      pulse_req();
      wait_cyc(FS_LEN - 20);
      pulse_req();
      wait_cyc(G + 6);
    end

    // request held high: back-to-back frames after each gap (R9)
    req = 1'b1;
    wait_cyc(6 * (FR_LEN + 1) + 4);
    req = 1'b0;
    wait_cyc(FR_LEN + 5);

    // reset in the middle of a frame (R8)
    pulse_req();
    wait_cyc(30);
    rst_n = 1'b0;
    wait_cyc(2);
    exp_q.delete();
    check_rest("mid-frame reset R8");
    rst_n = 1'b1;
    wait_cyc(4);

    for (int f = 0; f < 4; f++) begin
      pulse_req();
      wait_cyc(FR_LEN + 3 + f);
    end
    check("all words delivered R1", 32'(exp_q.size()), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    mismatched++;
    $display("FAIL watchdog R1: got %0d cycles expected fewer than %0d", cycles, 150000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule